// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous binary counter of `WIDTH` bits (16 states at the default width of 4). It can be preset from a parallel data bus and has two count enables. The parallel enable `cnt_go` is meant to be shared by every stage of a chain. The trickle enable `cnt_carry_in` also qualifies the terminal-count flag `wrap_out`. Several stages therefore chain into one wide synchronous counter or a programmable divider, without extra carry logic between them.

All state changes happen on the rising clock edge. The single exception is the asynchronous reset variant. An elaboration parameter picks the reset style. With `ASYNC_RST = 1`, an active-low reset clears the state immediately. With `ASYNC_RST = 0`, the active-low reset is sampled on the clock edge. Both variants have the same port list.

To chain stages, connect each stage's `wrap_out` to the next stage's `cnt_carry_in`. All stages share `clk`, `cnt_go` and `preset_n`. The control pins are plain level inputs and have no handshake: every clock edge performs exactly one action.

Top module: `casc_counter`

## Requirements
- R1: The state `cnt_q` is `WIDTH` bits wide and reads 0 after reset. Apart from an asynchronous clear, it changes only on a rising clock edge.
- R2: With `ASYNC_RST = 1`, `rst_n = 0` forces `cnt_q` to 0 at once, without a clock edge, and overrides every other input.
- R3: With `ASYNC_RST = 0`, `rst_n = 0` leaves `cnt_q` unchanged until the next rising edge. On that edge `cnt_q` becomes 0, even if a preset or a count is also requested.
- R4: When reset is inactive and `preset_n = 0`, the rising edge copies `preset_val` into `cnt_q`, whatever the values of `cnt_go` and `cnt_carry_in`.
- R5: When reset is inactive, `preset_n = 1` and `cnt_go = cnt_carry_in = 1`, the rising edge increments `cnt_q` by 1.
- R6: When reset is inactive, `preset_n = 1` and either `cnt_go` or `cnt_carry_in` is 0, `cnt_q` holds its value.
- R7: `wrap_out` is 1 exactly when `cnt_q` is all ones and `cnt_carry_in = 1`. It is combinational, so it follows `cnt_carry_in` without a clock edge. `preset_n` has no effect on it.
- R8: Counting from the all-ones state gives 0 on the next edge. During continuous counting, `wrap_out` is high for exactly the one cycle at the all-ones state.
- R9: Two stages chained through `wrap_out` into `cnt_carry_in`, with a shared `cnt_go`, `preset_n` and clock, behave as one counter of twice the width. The low stage's `preset_val` forms bits 3:0 of the combined value.
- R10: The `ASYNC_RST` parameter picks the reset style at elaboration. Both variants have an identical port list and identical preset, count and hold behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous or synchronous depending on `ASYNC_RST` |
| preset_n | input | 1 | Active-low parallel preset request |
| preset_val | input | WIDTH | Value loaded by a preset |
| cnt_go | input | 1 | Parallel count enable, shared by all stages in a chain |
| cnt_carry_in | input | 1 | Trickle count enable; also qualifies `wrap_out` |
| cnt_q | output | WIDTH | Current counter state |
| wrap_out | output | 1 | Terminal count: state all ones and `cnt_carry_in` high |

## Verification
The clocked properties assume that the control inputs are steady around each rising edge. Under that assumption, one sampled set of inputs per edge fully decides the next state. The asynchronous-clear property assumes that `rst_n` never changes exactly on an edge. The stimulus meets both assumptions by changing every input, including `rst_n`, a short time after the falling edge. It then checks the combinational `wrap_out` and any immediate clear before the next rising edge, and reads the registered state at the falling edge that follows.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Action selected for the next rising edge (reset is handled in the register).
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic     preset_n,
  input  logic     cnt_go,
  input  logic     cnt_carry_in,
  output cnt_act_e act
);
  // Fixed priority: preset over count over hold.
  always_comb begin
    if (!preset_n)                   act = ACT_LOAD;
    else if (cnt_go && cnt_carry_in) act = ACT_COUNT;
    else                             act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_act_e         act,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_comb begin
    unique case (act)
      ACT_LOAD:  nxt = load_val;
      ACT_COUNT: nxt = cur + STEP;   // wraps modulo 2**WIDTH
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             cnt_carry_in,
  output logic             wrap_out
);
  // Combinational so a carry ripples through a chain within one cycle.
  assign wrap_out = cnt_carry_in && (&q);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] preset_val,
  input  logic             cnt_go,
  input  logic             cnt_carry_in,
  output logic [WIDTH-1:0] cnt_q,
  output logic             wrap_out
);
  cnt_act_e         act;
  logic [WIDTH-1:0] nxt;

  cnt_ctrl u_ctrl (
    .preset_n    (preset_n),
    .cnt_go      (cnt_go),
    .cnt_carry_in(cnt_carry_in),
    .act         (act)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .act     (act),
    .cur     (cnt_q),
    .load_val(preset_val),
    .nxt     (nxt)
  );

  cnt_reg #(.WIDTH(WIDTH), .ASYNC_RST(ASYNC_RST)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .nxt  (nxt),
    .q    (cnt_q)
  );

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .q           (cnt_q),
    .cnt_carry_in(cnt_carry_in),
    .wrap_out    (wrap_out)
  );
endmodule

// File: rtl/cnt_chk.sv
module cnt_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preset_n,
  input logic [WIDTH-1:0] preset_val,
  input logic             cnt_go,
  input logic             cnt_carry_in,
  input logic [WIDTH-1:0] cnt_q,
  input logic             wrap_out
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOPV = '1;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R4: preset wins over both enables
  p_load_r4: assert property (@(posedge clk) disable iff (!armed || !rst_n)
    (!preset_n) |=> (cnt_q == $past(preset_val)));

  // R5: increment when both enables high
  p_count_r5: assert property (@(posedge clk) disable iff (!armed || !rst_n)
    (preset_n && cnt_go && cnt_carry_in) |=> (cnt_q == $past(cnt_q) + ONE));

  // R6: hold when either enable low
  p_hold_r6: assert property (@(posedge clk) disable iff (!armed || !rst_n)
    (preset_n && !(cnt_go && cnt_carry_in)) |=> $stable(cnt_q));

  // R7: terminal count tracks state and trickle enable
  p_term_r7: assert property (@(posedge clk) disable iff (!armed)
    wrap_out == ((cnt_q == TOPV) && cnt_carry_in));

  // R8: wrap from all ones to zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!armed || !rst_n)
    (preset_n && cnt_go && cnt_carry_in && cnt_q == TOPV) |=> (cnt_q == '0));

  generate
    if (ASYNC_RST) begin : g_a
      // R2: reset low already holds the state at zero at the edge
      p_aclr_r2: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n) |-> (cnt_q == '0));
    end else begin : g_s
      // R3: synchronous clear on the edge after reset is sampled low
      p_sclr_r3: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n) |=> (cnt_q == '0));
    end
  endgenerate
endmodule

bind casc_counter cnt_chk #(.WIDTH(WIDTH), .ASYNC_RST(ASYNC_RST)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .preset_n    (preset_n),
  .preset_val  (preset_val),
  .cnt_go      (cnt_go),
  .cnt_carry_in(cnt_carry_in),
  .cnt_q       (cnt_q),
  .wrap_out    (wrap_out)
);

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b1, ld_n = 1'b1, go = 1'b0, ci = 1'b0;
  logic [3:0] d4 = '0;
  logic [7:0] d8 = '0;
  logic [3:0] qa, qs, c_lo, c_hi;
  logic       ta, ts, t_lo, t_hi;

  // R10: same ports, both reset styles
  casc_counter #(.WIDTH(4), .ASYNC_RST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .preset_n(ld_n), .preset_val(d4),
    .cnt_go(go), .cnt_carry_in(ci), .cnt_q(qa), .wrap_out(ta));
  casc_counter #(.WIDTH(4), .ASYNC_RST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .preset_n(ld_n), .preset_val(d4),
    .cnt_go(go), .cnt_carry_in(ci), .cnt_q(qs), .wrap_out(ts));
  // R9: two-stage chain wrapper
  casc_counter #(.WIDTH(4), .ASYNC_RST(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .preset_n(ld_n), .preset_val(d8[3:0]),
    .cnt_go(go), .cnt_carry_in(ci), .cnt_q(c_lo), .wrap_out(t_lo));
  casc_counter #(.WIDTH(4), .ASYNC_RST(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_n), .preset_n(ld_n), .preset_val(d8[7:4]),
    .cnt_go(go), .cnt_carry_in(t_lo), .cnt_q(c_hi), .wrap_out(t_hi));

  typedef struct {
    logic [3:0] a;
    logic [3:0] s;
    logic [7:0] c;
    string      req;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;
  logic [3:0] ma = '0, ms = '0;
  logic [7:0] mc = '0;
  bit tc_on = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare registered state at each falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.req, " async q"}, {4'h0, qa}, {4'h0, e.a});
      chk({e.req, " sync q"},  {4'h0, qs}, {4'h0, e.s});
      chk({e.req, " R9 chain"}, {c_hi, c_lo}, e.c);
    end
  end

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic step(input string req, input logic r, input logic l, input logic g,
                      input logic c, input logic [3:0] v4, input logic [7:0] v8);
    exp_t e;
    @(negedge clk);
    #2;
    rst_n = r; ld_n = l; go = g; ci = c; d4 = v4; d8 = v8;
    if (!r) ma = '0;
    #1;
    if (tc_on) begin
      chk("R7 async tc", {7'd0, ta}, {7'd0, (ma == 4'hF) && c});
      chk("R7 sync tc",  {7'd0, ts}, {7'd0, (ms == 4'hF) && c});
      chk("R9 chain tc", {7'd0, t_hi}, {7'd0, (mc == 8'hFF) && c});
      if (!r) begin
        chk("R2 immediate clear", {4'h0, qa}, 8'h00);
        chk("R3 no clear before edge", {4'h0, qs}, {4'h0, ms});
      end
    end
    if (!r)                begin ma = '0;  ms = '0;  mc = '0; end
    else if (!l)           begin ma = v4;  ms = v4;  mc = v8; end
    else if (g && c)       begin ma = ma + 4'd1; ms = ms + 4'd1; mc = mc + 8'd1; end
    e.a = ma; e.s = ms; e.c = mc; e.req = req;
    sb.push_back(e);
    @(posedge clk);
    tc_on = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    step("R1 reset", 0, 1, 0, 0, 4'h0, 8'h00);
    step("R1 reset", 0, 1, 1, 1, 4'h0, 8'h00);
    step("R4 load no enables", 1, 0, 0, 0, 4'hD, 8'hFD);
    for (int i = 0; i < 5; i++) step("R8 count wrap", 1, 1, 1, 1, 4'h0, 8'h00);
    step("R4 load 15", 1, 0, 0, 1, 4'hF, 8'hFF);
    step("R6 hold go low", 1, 1, 0, 1, 4'h1, 8'h11);
    step("R6 hold carry low", 1, 1, 1, 0, 4'h2, 8'h22);
    step("R7 tc with preset low", 1, 0, 1, 1, 4'h3, 8'h0E);
    for (int i = 0; i < 3; i++) step("R5 count carry", 1, 1, 1, 1, 4'h0, 8'h00);
    step("R3 reset over load", 0, 0, 1, 1, 4'h9, 8'h99);
    step("R3 reset over count", 0, 1, 1, 1, 4'h9, 8'h99);
    step("R4 load with enables", 1, 0, 1, 1, 4'hA, 8'hF0);
    for (int i = 0; i < 40; i++) step("R5 long count", 1, 1, 1, 1, 4'h0, 8'h00);
    step("R6 hold both low", 1, 1, 0, 0, 4'h5, 8'h55);
    step("R10 final load", 1, 0, 0, 0, 4'h6, 8'h66);
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule